// File: doc/BRIEF.md
# Integer Execute Stage with Signed-Overflow Trap

This block is the integer execute stage of a small RISC pipeline. Each cycle it may accept one decoded operation together with two 32-bit register operands, a 16-bit immediate and a 5-bit shift count. One clock later it presents a 32-bit result and a write-enable for the destination register. Trapping adds and subtracts that overflow instead raise a trap flag and withhold the write-enable.

The operations are:

- add and subtract, each in a trapping and a wrapping form;
- the four bitwise operations AND, OR, XOR and NOR;
- signed and unsigned less-than compares;
- logical left, logical right and arithmetic right shifts;
- placing an immediate in the upper half of the word.

A second-operand selector picks the register operand, the sign-extended immediate or the zero-extended immediate. This lets the same operation codes serve both the register forms and the immediate forms of each instruction.

Top module: `alu_exec_stage`

## Requirements
- R1: For operation codes 0 (trapping add), 1 (wrapping add), 2 (trapping subtract) and 3 (wrapping subtract), `result` is opa plus or minus the selected second operand, modulo 2^32. `result` carries this value even when the operation traps.
- R2: Codes 0 and 2 raise `ovf_trap` for one cycle when the signed two's-complement result does not fit in 32 bits. In that cycle `res_vld` is low, so the destination is not written.
- R3: The wrapping codes 1 and 3 never raise `ovf_trap`, whatever the operands.
- R4: Code 4 gives AND, 5 gives OR, 6 gives XOR and 7 gives NOR of opa with the selected second operand. NOR with a zero operand yields the bitwise NOT of opa. None of these codes traps.
- R5: Code 8 yields 1 when opa is below the second operand as signed integers and 0 otherwise. Code 9 does the same compare as unsigned integers. Bits 31..1 of a compare result are always zero.
- R6: `b_src` selects the second operand. The value 0 (or 3) selects opb. The value 1 selects imm with bit 15 copied into bits 31..16. The value 2 selects imm with bits 31..16 cleared. An unsigned compare with `b_src`=1 compares against the sign-extended immediate read as an unsigned 32-bit value.
- R7: Code 10 shifts opa left by shamt, filling with zeros. Code 11 shifts opa right, filling with zeros. Code 12 shifts opa right, filling with copies of bit 31. The amount shamt ranges over 0..31, and shifting zero left by zero yields zero (a no-operation).
- R8: Code 13 yields imm in bits 31..16 and zero in bits 15..0.
- R9: The outputs follow the accepted operation by exactly one clock. A cycle with `in_vld` low produces `res_vld` low and `ovf_trap` low in the next cycle.
- R10: While `rst` is high, `res_vld`, `ovf_trap` and `result` are all zero.
- R11: The unused codes 14 and 15 yield a zero result with `res_vld` following `in_vld`, and they never trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (see R1..R11) |
| b_src | input | 2 | Second-operand select: 0 register, 1 sign-extended imm, 2 zero-extended imm |
| opa | input | 32 | First operand |
| opb | input | 32 | Second register operand |
| imm | input | 16 | Immediate constant |
| shamt | input | 5 | Shift amount |
| res_vld | output | 1 | Destination write-enable for the result |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow trap of a trapping add or subtract |

## Verification
The only state in this block is the output register, so any fault in the operand select, the adder, the shifter or the result mux shows up at the ports one clock after the operation is accepted. A reference model in the bench computes each expected result and flag with wide-integer arithmetic. The bench compares `result`, `res_vld` and `ovf_trap` on every cycle. The stimulus is a fixed set of operands at the signed limits, at zero and at the extreme shift amounts, followed by a long run of random operations. With this stimulus, a wrong overflow rule, a wrong extension or a wrong shift fill breaks the comparison within the first few dozen cycles.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int XLEN = 32;
    localparam int IMMW = 16;

    typedef enum logic [3:0] {
        OP_ADD_TRAP = 4'd0,
        OP_ADD_WRAP = 4'd1,
        OP_SUB_TRAP = 4'd2,
        OP_SUB_WRAP = 4'd3,
        OP_AND      = 4'd4,
        OP_OR       = 4'd5,
        OP_XOR      = 4'd6,
        OP_NOR      = 4'd7,
        OP_LT_S     = 4'd8,
        OP_LT_U     = 4'd9,
        OP_SHL      = 4'd10,
        OP_SHR_L    = 4'd11,
        OP_SHR_A    = 4'd12,
        OP_UPPER    = 4'd13,
        OP_RSV_E    = 4'd14,
        OP_RSV_F    = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        BSRC_REG  = 2'd0,
        BSRC_SIMM = 2'd1,
        BSRC_ZIMM = 2'd2,
        BSRC_RSV  = 2'd3
    } bsrc_e;

    typedef struct packed {
        logic vld;
        logic trap;
    } out_flags_t;

    // operations that drive the adder in subtract mode
    function automatic logic uses_sub(alu_op_e o);
        return (o == OP_SUB_TRAP) || (o == OP_SUB_WRAP) ||
               (o == OP_LT_S) || (o == OP_LT_U);
    endfunction

    function automatic logic can_trap(alu_op_e o);
        return (o == OP_ADD_TRAP) || (o == OP_SUB_TRAP);
    endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
    import alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMMW
) (
    input  logic [1:0]    b_src,
    input  logic [W-1:0]  reg_b,
    input  logic [IW-1:0] imm,
    output logic [W-1:0]  opnd_b
);
    localparam int EXT = W - IW;

    bsrc_e sel;
    assign sel = bsrc_e'(b_src);

    always_comb begin
        unique case (sel)
            BSRC_SIMM: opnd_b = {{EXT{imm[IW-1]}}, imm};
            BSRC_ZIMM: opnd_b = {{EXT{1'b0}}, imm};
            default:   opnd_b = reg_b;
        endcase
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] bx;
    logic [W:0]   full;

    assign bx    = sub ? ~b : b;
    assign full  = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, sub};
    assign sum   = full[W-1:0];
    assign carry = full[W];
    // same-sign inputs whose sum changes sign
    assign ovf   = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          to_left,
    input  logic          arith,
    output logic [W-1:0]  dout
);
    logic [W-1:0] rin;
    logic [W-1:0] rout;
    logic         fill;
    logic [W-1:0] stage [SW+1];

    // left shifts reuse the right shifter on a bit-reversed word
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign rin[i]  = to_left ? din[W-1-i]  : din[i];
        assign dout[i] = to_left ? rout[W-1-i] : rout[i];
    end

    assign fill     = arith & ~to_left & din[W-1];
    assign stage[0] = rin;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int D = 1 << k;
        assign stage[k+1] = amt[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
    end

    assign rout = stage[SW];
endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage
    import alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMMW,
    parameter int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_vld,
    input  logic [3:0]    op,
    input  logic [1:0]    b_src,
    input  logic [W-1:0]  opa,
    input  logic [W-1:0]  opb,
    input  logic [IW-1:0] imm,
    input  logic [SW-1:0] shamt,
    output logic          res_vld,
    output logic [W-1:0]  result,
    output logic          ovf_trap
);
    localparam int LOW = W - IW;

    alu_op_e      opc;
    logic [W-1:0] bsel;
    logic [W-1:0] as_sum;
    logic         as_carry;
    logic         as_ovf;
    logic [W-1:0] sh_out;
    logic         lt_s;
    logic         lt_u;
    logic [W-1:0] nxt_res;
    out_flags_t   nxt_flags;
    out_flags_t   flags_q;

    assign opc = alu_op_e'(op);

    alu_operand_sel #(.W(W), .IW(IW)) u_bsel (
        .b_src  (b_src),
        .reg_b  (opb),
        .imm    (imm),
        .opnd_b (bsel)
    );

    alu_addsub #(.W(W)) u_addsub (
        .a     (opa),
        .b     (bsel),
        .sub   (uses_sub(opc)),
        .sum   (as_sum),
        .carry (as_carry),
        .ovf   (as_ovf)
    );

    alu_shifter #(.W(W), .SW(SW)) u_shift (
        .din     (opa),
        .amt     (shamt),
        .to_left (opc == OP_SHL),
        .arith   (opc == OP_SHR_A),
        .dout    (sh_out)
    );

    // compares come from the shared subtractor
    assign lt_s = as_sum[W-1] ^ as_ovf;
    assign lt_u = ~as_carry;

    always_comb begin
        unique case (opc)
            OP_ADD_TRAP, OP_ADD_WRAP,
            OP_SUB_TRAP, OP_SUB_WRAP: nxt_res = as_sum;
            OP_AND:   nxt_res = opa & bsel;
            OP_OR:    nxt_res = opa | bsel;
            OP_XOR:   nxt_res = opa ^ bsel;
            OP_NOR:   nxt_res = ~(opa | bsel);
            OP_LT_S:  nxt_res = {{(W-1){1'b0}}, lt_s};
            OP_LT_U:  nxt_res = {{(W-1){1'b0}}, lt_u};
            OP_SHL, OP_SHR_L, OP_SHR_A: nxt_res = sh_out;
            OP_UPPER: nxt_res = {imm, {LOW{1'b0}}};
            default:  nxt_res = '0;
        endcase
    end

    always_comb begin
        nxt_flags.trap = in_vld & can_trap(opc) & as_ovf;
        nxt_flags.vld  = in_vld & ~nxt_flags.trap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            result  <= '0;
        end else begin
            flags_q <= nxt_flags;
            result  <= nxt_res;
        end
    end

    assign res_vld  = flags_q.vld;
    assign ovf_trap = flags_q.trap;
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk
    import alu_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMMW
) (
    input logic          clk,
    input logic          rst,
    input logic          in_vld,
    input logic [3:0]    op,
    input logic [IW-1:0] imm,
    input logic          res_vld,
    input logic [W-1:0]  result,
    input logic          ovf_trap
);
    // R2
    trap_blocks_wb_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_trap |-> !res_vld);

    // R3
    wrap_never_traps_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (op == OP_ADD_WRAP || op == OP_SUB_WRAP)) |=> !ovf_trap);

    // R4
    logic_op_writes_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && op >= OP_AND && op <= OP_NOR) |=> (res_vld && !ovf_trap));

    // R5
    compare_is_bool_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && (op == OP_LT_S || op == OP_LT_U)) |=> (result[W-1:1] == '0));

    // R8
    upper_imm_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && op == OP_UPPER) |=> (result == {$past(imm), {(W-IW){1'b0}}}));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> (!res_vld && !ovf_trap));

    // R11
    spare_code_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && op >= OP_RSV_E) |=> (res_vld && result == '0));
endmodule

bind alu_exec_stage alu_exec_chk #(.W(W), .IW(IW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .op       (op),
    .imm      (imm),
    .res_vld  (res_vld),
    .result   (result),
    .ovf_trap (ovf_trap)
);

// File: tb/sim_alu_exec_stage.sv
`timescale 1ns/1ps
module sim_alu_exec_stage;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [3:0]  op = '0;
    logic [1:0]  b_src = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [15:0] imm = '0;
    logic [4:0]  shamt = '0;
    logic        res_vld;
    logic [31:0] result;
    logic        ovf_trap;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    alu_exec_stage u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op(op), .b_src(b_src),
        .opa(opa), .opb(opb), .imm(imm), .shamt(shamt),
        .res_vld(res_vld), .result(result), .ovf_trap(ovf_trap)
    );

    typedef struct {
        logic        vld;
        logic        trap;
        logic [31:0] res;
        logic        chk_res;
        string       tag_res;
        string       tag_flag;
    } exp_t;

    exp_t q[$];

    function automatic void ref_model(input logic [3:0] o, input logic [1:0] bs,
                                      input logic [31:0] a, input logic [31:0] b,
                                      input logic [15:0] im, input logic [4:0] sh,
                                      output logic [31:0] r, output logic t);
        logic [31:0] bb;
        longint sa, sb, s;
        bb = (bs == 2'd1) ? {{16{im[15]}}, im} : (bs == 2'd2) ? {16'h0, im} : b;
        sa = longint'($signed(a));
        sb = longint'($signed(bb));
        t = 1'b0;
        case (o)
            4'd0, 4'd1: begin
                s = sa + sb; r = a + bb;
                t = (o == 4'd0) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd2, 4'd3: begin
                s = sa - sb; r = a - bb;
                t = (o == 4'd2) && (s > 64'sd2147483647 || s < -64'sd2147483648);
            end
            4'd4:  r = a & bb;
            4'd5:  r = a | bb;
            4'd6:  r = a ^ bb;
            4'd7:  r = ~(a | bb);
            4'd8:  r = (sa < sb) ? 32'd1 : 32'd0;
            4'd9:  r = (a < bb) ? 32'd1 : 32'd0;
            4'd10: r = a << sh;
            4'd11: r = a >> sh;
            4'd12: r = $unsigned($signed(a) >>> sh);
            4'd13: r = {im, 16'h0};
            default: r = 32'h0;
        endcase
    endfunction

    function automatic string res_tag(input logic [3:0] o, input logic [1:0] bs);
        if (bs == 2'd1 || bs == 2'd2) return "R6";
        if (o <= 4'd3)  return "R1";
        if (o <= 4'd7)  return "R4";
        if (o <= 4'd9)  return "R5";
        if (o <= 4'd12) return "R7";
        if (o == 4'd13) return "R8";
        return "R11";
    endfunction

    function automatic string flag_tag(input logic v, input logic [3:0] o);
        if (!v) return "R9";
        if (o == 4'd0 || o == 4'd2) return "R2";
        if (o == 4'd1 || o == 4'd3) return "R3";
        if (o >= 4'd14) return "R11";
        return "R9";
    endfunction

    task automatic check_front();
        exp_t e;
        if (q.size() == 0) return;
        e = q.pop_front();
        n_chk++;
        if (res_vld !== e.vld || ovf_trap !== e.trap) begin
            n_bad++;
            $display("FAIL %s flags vld/trap actual %b/%b expected %b/%b",
                     e.tag_flag, res_vld, ovf_trap, e.vld, e.trap);
        end
        if (e.chk_res) begin
            n_chk++;
            if (result !== e.res) begin
                n_bad++;
                $display("FAIL %s result actual %h expected %h", e.tag_res, result, e.res);
            end
        end
    endtask

    task automatic issue(input logic v, input logic [3:0] o, input logic [1:0] bs,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh);
        exp_t e;
        logic [31:0] r;
        logic t;
        @(negedge clk);
        check_front();
        in_vld = v; op = o; b_src = bs; opa = a; opb = b; imm = im; shamt = sh;
        ref_model(o, bs, a, b, im, sh, r, t);
        e.vld = v & ~(v & t);
        e.trap = v & t;
        e.res = r;
        e.chk_res = v;
        e.tag_res = res_tag(o, bs);
        e.tag_flag = flag_tag(v, o);
        q.push_back(e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;   // R10 reset state
        if (res_vld !== 1'b0 || ovf_trap !== 1'b0 || result !== 32'h0) begin
            n_bad++;
            $display("FAIL R10 reset outputs actual %b/%b/%h expected 0/0/00000000",
                     res_vld, ovf_trap, result);
        end
        rst = 1'b0;

        // R2 / R3 signed limits
        issue(1, 4'd0, 2'd0, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        issue(1, 4'd1, 2'd0, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        issue(1, 4'd2, 2'd0, 32'h80000000, 32'h1, 16'h0, 5'd0);
        issue(1, 4'd3, 2'd0, 32'h80000000, 32'h1, 16'h0, 5'd0);
        issue(1, 4'd2, 2'd0, 32'h0, 32'h80000000, 16'h0, 5'd0);
        issue(1, 4'd0, 2'd0, 32'h80000000, 32'h80000000, 16'h0, 5'd0);
        issue(1, 4'd0, 2'd0, 32'hffffffff, 32'h1, 16'h0, 5'd0);
        issue(0, 4'd0, 2'd0, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        // R4 NOR with zero is NOT
        issue(1, 4'd7, 2'd0, 32'h1234abcd, 32'h0, 16'h0, 5'd0);
        // R5 compares
        issue(1, 4'd8, 2'd0, 32'hffffffff, 32'h1, 16'h0, 5'd0);
        issue(1, 4'd9, 2'd0, 32'hffffffff, 32'h1, 16'h0, 5'd0);
        issue(1, 4'd8, 2'd0, 32'h7fffffff, 32'h80000000, 16'h0, 5'd0);
        // R6 extension
        issue(1, 4'd1, 2'd1, 32'h10, 32'h0, 16'hffff, 5'd0);
        issue(1, 4'd5, 2'd2, 32'h0, 32'h0, 16'hffff, 5'd0);
        issue(1, 4'd9, 2'd1, 32'h5, 32'h0, 16'hffff, 5'd0);
        issue(1, 4'd8, 2'd1, 32'h5, 32'h0, 16'hffff, 5'd0);
        issue(1, 4'd0, 2'd1, 32'h80000000, 32'h0, 16'hffff, 5'd0);
        // R7 shifts
        issue(1, 4'd10, 2'd0, 32'h0, 32'h0, 16'h0, 5'd0);
        issue(1, 4'd10, 2'd0, 32'h80000001, 32'h0, 16'h0, 5'd31);
        issue(1, 4'd11, 2'd0, 32'h80000000, 32'h0, 16'h0, 5'd31);
        issue(1, 4'd12, 2'd0, 32'h80000000, 32'h0, 16'h0, 5'd31);
        issue(1, 4'd12, 2'd0, 32'h40000000, 32'h0, 16'h0, 5'd4);
        issue(1, 4'd12, 2'd0, 32'h8000f000, 32'h0, 16'h0, 5'd0);
        // R8 upper immediate
        issue(1, 4'd13, 2'd0, 32'hffffffff, 32'hffffffff, 16'hbeef, 5'd7);
        // R11 spare codes
        issue(1, 4'd14, 2'd0, 32'h7fffffff, 32'h1, 16'h1, 5'd1);
        issue(1, 4'd15, 2'd1, 32'h80000000, 32'h1, 16'hffff, 5'd1);

        // random traffic with corner-biased operands
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] a, b;
            a = $urandom;
            b = $urandom;
            if ((i % 7) == 0) a = {a[31], {31{~a[31]}}};
            if ((i % 11) == 0) b = {b[31], {31{~b[31]}}};
            issue(($urandom % 10) != 0, 4'($urandom), 2'($urandom), a, b,
                  16'($urandom), 5'($urandom));
        end
        issue(0, 4'd0, 2'd0, 32'h0, 32'h0, 16'h0, 5'd0);
        @(negedge clk);
        check_front();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule